// File: doc/BRIEF.md
# Accumulator Processor ALU with Flags

This block is the arithmetic and logic stage of a small accumulator-style processor. Each cycle it can accept one operation together with a register operand (the accumulator, or an index register for compares), a memory operand and the current processor flags. It works out the result byte, whether that result should be written back to a destination, and the new negative, overflow, zero and carry flags. Arithmetic is binary only. The decimal flag is carried through unchanged.

The datapath is combinational. The result, write-enable and flags are captured in one output register stage, so a valid operation presented before a rising edge appears on the outputs after that edge. Subtraction adds the inverted memory operand and uses the incoming carry as not-borrow. Compare uses the same adder with the carry-in forced to one. Shifts and rotates act on the memory operand port; for the accumulator forms, the caller puts the accumulator on that port.

Top module: `alu8_core`

## Requirements
- R1: Flags are packed as bit 4 N, bit 3 V, bit 2 D, bit 1 Z, bit 0 C on both `flags_i` and `flags_o`. Op code 0 (add) gives result (reg + mem + C) mod 2^W, sets C to the carry out, and sets N to the result MSB and Z when the result is zero.
- R2: On op codes 0 and 1, V is set exactly when the signed sum of reg, the effective operand and C falls outside the two's-complement range of W bits.
- R3: Op code 1 (subtract with borrow) gives the same result and flags as op code 0 with mem replaced by its bitwise complement, with C used as not-borrow.
- R4: Op code 2 (compare) sets C when reg >= mem (unsigned), sets N and Z from (reg - mem) mod 2^W, leaves V unchanged and does not assert a write.
- R5: Op codes 3, 4 and 5 produce reg AND mem, reg OR mem and reg XOR mem respectively. They set N and Z from the result and leave C and V unchanged.
- R6: Op code 6 (bit test) sets N from mem bit W-1, V from mem bit W-2 and Z when (reg AND mem) is zero, so N and Z may both be set. C is unchanged, the result is reg AND mem, and no write is asserted.
- R7: Op code 8 (logical right shift of mem) puts 0 into the MSB. Op code 10 (rotate right of mem) puts the old C into the MSB. Both put old mem bit 0 into C, set N and Z from the result and leave V unchanged.
- R8: Op code 7 (left shift of mem) puts 0 into bit 0. Op code 9 (rotate left of mem) puts the old C into bit 0. Both put old mem bit W-1 into C, set N and Z from the result and leave V unchanged.
- R9: The D flag is copied from input to output unchanged, and its value has no effect on any result or other flag.
- R10: `wr_o` is high after an accepted op with code 0, 1, 3, 4, 5, 7, 8, 9 or 10, and low after codes 2, 6 and 11 to 15, and in any cycle that follows an edge where `valid_i` was low.
- R11: An op accepted on a rising edge with `valid_i` high appears on the outputs after that edge, with `valid_o` high. When `valid_i` is low, `valid_o` falls and `res_o` and `flags_o` hold their previous values.
- R12: While `rst_ni` is low, every output is zero.
- R13: Op codes 11 to 15 give result 0, leave all flags unchanged and assert no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Operation code |
| reg_i | input | W | Register operand (accumulator or index) |
| mem_i | input | W | Memory operand; the shift/rotate source |
| flags_i | input | 5 | Current flags {N,V,D,Z,C} |
| valid_o | output | 1 | Registered result is valid |
| wr_o | output | 1 | Write result back to the destination |
| res_o | output | W | Result |
| flags_o | output | 5 | Next flags {N,V,D,Z,C} |

## Verification
The assertions assume that `valid_i`, `op_i` and the operands are stable and known at each rising edge. They also assume the operation code uses the 4-bit field as stated, and that W is at least 2 so that a bit W-2 exists for the bit test. The bench drives every input at the falling edge and holds it through the next rising edge. It uses only W values of 4 and 8, and it covers all sixteen codes, including the undefined ones, so every stimulus meets these assumptions.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int unsigned OP_W = 4;
  localparam int unsigned FLG_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADC = 4'd0,
    OP_SBC = 4'd1,
    OP_CMP = 4'd2,
    OP_AND = 4'd3,
    OP_ORA = 4'd4,
    OP_EOR = 4'd5,
    OP_BIT = 4'd6,
    OP_ASL = 4'd7,
    OP_LSR = 4'd8,
    OP_ROL = 4'd9,
    OP_ROR = 4'd10
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic v;
    logic d;
    logic z;
    logic c;
  } flags_t;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_sel_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         inv_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   full;

  assign b_eff = inv_i ? ~b_i : b_i;
  assign full  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
  assign sum_o  = full[W-1:0];
  assign cout_o = full[W];
  // like-signed inputs producing an opposite-signed sum
  assign ovf_o  = (a_i[W-1] ~^ b_eff[W-1]) & (full[W-1] ^ a_i[W-1]);
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] val_i,
  input  logic         cin_i,
  input  logic         right_i,
  input  logic         rot_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  logic fill;

  assign fill = rot_i & cin_i;

  always_comb begin
    if (right_i) begin
      res_o  = {fill, val_i[W-1:1]};
      cout_o = val_i[0];
    end else begin
      res_o  = {val_i[W-2:0], fill};
      cout_o = val_i[W-1];
    end
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_sel_e   sel_i,
  output logic [W-1:0] res_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      unique case (sel_i)
        LG_OR:   res_o[i] = a_i[i] | b_i[i];
        LG_XOR:  res_o[i] = a_i[i] ^ b_i[i];
        default: res_o[i] = a_i[i] & b_i[i];
      endcase
    end
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] reg_i,
  input  logic [W-1:0] mem_i,
  input  logic [4:0]   flags_i,
  output logic         valid_o,
  output logic         wr_o,
  output logic [W-1:0] res_o,
  output logic [4:0]   flags_o
);
  alu_op_e      op;
  flags_t       f_in, f_nx, f_q;
  logic [W-1:0] add_sum, sh_res, lg_res, res_nx, res_q;
  logic         add_cout, add_ovf, sh_cout;
  logic         add_inv, add_cin, sh_right, sh_rot;
  logic_sel_e   lg_sel;
  logic         wr_nx, wr_q, valid_q;

  assign op   = alu_op_e'(op_i);
  assign f_in = flags_t'(flags_i);

  // compare reuses the subtract path with carry forced
  assign add_inv  = (op == OP_SBC) || (op == OP_CMP);
  assign add_cin  = (op == OP_CMP) ? 1'b1 : f_in.c;
  assign sh_right = (op == OP_LSR) || (op == OP_ROR);
  assign sh_rot   = (op == OP_ROL) || (op == OP_ROR);

  always_comb begin
    unique case (op)
      OP_ORA:  lg_sel = LG_OR;
      OP_EOR:  lg_sel = LG_XOR;
      default: lg_sel = LG_AND;
    endcase
  end

  alu8_addsub #(.W(W)) u_addsub (
    .a_i   (reg_i),
    .b_i   (mem_i),
    .inv_i (add_inv),
    .cin_i (add_cin),
    .sum_o (add_sum),
    .cout_o(add_cout),
    .ovf_o (add_ovf)
  );

  alu8_shift #(.W(W)) u_shift (
    .val_i  (mem_i),
    .cin_i  (f_in.c),
    .right_i(sh_right),
    .rot_i  (sh_rot),
    .res_o  (sh_res),
    .cout_o (sh_cout)
  );

  alu8_logic #(.W(W)) u_logic (
    .a_i  (reg_i),
    .b_i  (mem_i),
    .sel_i(lg_sel),
    .res_o(lg_res)
  );

  always_comb begin
    f_nx   = f_in;
    res_nx = '0;
    wr_nx  = 1'b0;
    unique case (op)
      OP_ADC, OP_SBC: begin
        res_nx = add_sum;
        wr_nx  = 1'b1;
        f_nx.c = add_cout;
        f_nx.v = add_ovf;
      end
      OP_CMP: begin
        res_nx = add_sum;
        f_nx.c = add_cout;
      end
      OP_AND, OP_ORA, OP_EOR: begin
        res_nx = lg_res;
        wr_nx  = 1'b1;
      end
      OP_BIT: res_nx = lg_res;
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        res_nx = sh_res;
        wr_nx  = 1'b1;
        f_nx.c = sh_cout;
      end
      default: ;
    endcase
    if (op == OP_BIT) begin
      f_nx.n = mem_i[W-1];
      f_nx.v = mem_i[W-2];
      f_nx.z = (lg_res == '0);
    end else if (op <= OP_ROR) begin
      f_nx.n = res_nx[W-1];
      f_nx.z = (res_nx == '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      wr_q    <= 1'b0;
      res_q   <= '0;
      f_q     <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        wr_q  <= wr_nx;
        res_q <= res_nx;
        f_q   <= f_nx;
      end
    end
  end

  assign valid_o = valid_q;
  assign wr_o    = valid_q & wr_q;
  assign res_o   = res_q;
  assign flags_o = f_q;
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [3:0]   op_i,
  input logic [W-1:0] reg_i,
  input logic [W-1:0] mem_i,
  input logic [4:0]   flags_i,
  input logic         valid_o,
  input logic         wr_o,
  input logic [W-1:0] res_o,
  input logic [4:0]   flags_o
);
  // R4
  cmp_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_CMP |=> flags_o[0] == ($past(reg_i) >= $past(mem_i)) && flags_o[3] == $past(flags_i[3]) && !wr_o);

  // R5
  logic_keep_cv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == OP_AND || op_i == OP_ORA || op_i == OP_EOR) |=>
      flags_o[0] == $past(flags_i[0]) && flags_o[3] == $past(flags_i[3]));

  // R6
  bit_nv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_BIT |=> flags_o[4] == $past(mem_i[W-1]) && flags_o[3] == $past(mem_i[W-2]) && !wr_o);

  // R9
  dec_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> flags_o[2] == $past(flags_i[2]));

  // R10
  no_valid_no_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !wr_o);

  // R10
  wr_zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && wr_o |-> flags_o[1] == (res_o == '0));

  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(res_o) && $stable(flags_o));

  // R13
  undef_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i > OP_ROR |=> flags_o == $past(flags_i) && !wr_o && res_o == '0);

  // R12
  always_comb begin
    if (!rst_ni) begin
      reset_out_chk: assert (!valid_o && !wr_o && res_o == '0 && flags_o == '0);
    end
  end
endmodule

bind alu8_core alu8_chk #(.W(W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .op_i   (op_i),
  .reg_i  (reg_i),
  .mem_i  (mem_i),
  .flags_i(flags_i),
  .valid_o(valid_o),
  .wr_o   (wr_o),
  .res_o  (res_o),
  .flags_o(flags_o)
);

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] a8 = '0, m8 = '0;
  logic [4:0] fl = '0;
  logic       v8_o, wr8_o, v4_o, wr4_o;
  logic [7:0] res8_o;
  logic [3:0] res4_o;
  logic [4:0] fl8_o, fl4_o;
  int         n_cmp = 0, n_bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  alu8_core #(.W(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .reg_i(a8[3:0]), .mem_i(m8[3:0]), .flags_i(fl),
    .valid_o(v4_o), .wr_o(wr4_o), .res_o(res4_o), .flags_o(fl4_o)
  );

  alu8_core #(.W(8)) dut8 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .reg_i(a8), .mem_i(m8), .flags_i(fl),
    .valid_o(v8_o), .wr_o(wr8_o), .res_o(res8_o), .flags_o(fl8_o)
  );

  // returns {valid, wr, N, V, D, Z, C, res[7:0]}
  function automatic logic [14:0] ref_fn(int w, int opc, int a, int m, logic [4:0] f);
    int   mask = (1 << w) - 1;
    int   msb  = 1 << (w - 1);
    int   r = 0, mm, s, so, sa, sm, cin;
    logic n = f[4], v = f[3], z = f[1], c = f[0], wr = 1'b0, upd = 1'b0;
    logic [7:0] r8;
    cin = int'(f[0]);
    case (opc)
      0, 1: begin
        mm = (opc == 1) ? (~m) & mask : m;
        s  = a + mm + cin;
        r  = s & mask;
        c  = (s > mask);
        sa = (a & msb) != 0 ? a - (mask + 1) : a;
        sm = (mm & msb) != 0 ? mm - (mask + 1) : mm;
        so = sa + sm + cin;
        v  = (so > msb - 1) || (so < -msb);
        wr = 1'b1; upd = 1'b1;
      end
      2: begin r = (a - m) & mask; c = (a >= m); upd = 1'b1; end
      3: begin r = a & m; wr = 1'b1; upd = 1'b1; end
      4: begin r = a | m; wr = 1'b1; upd = 1'b1; end
      5: begin r = a ^ m; wr = 1'b1; upd = 1'b1; end
      6: begin
        r = a & m;
        n = (m & msb) != 0;
        v = (m & (msb >> 1)) != 0;
        z = (r == 0);
      end
      7: begin c = (m & msb) != 0; r = (m << 1) & mask; wr = 1'b1; upd = 1'b1; end
      8: begin c = (m & 1) != 0; r = m >> 1; wr = 1'b1; upd = 1'b1; end
      9: begin c = (m & msb) != 0; r = ((m << 1) | cin) & mask; wr = 1'b1; upd = 1'b1; end
      10: begin c = (m & 1) != 0; r = (m >> 1) | (cin != 0 ? msb : 0); wr = 1'b1; upd = 1'b1; end
      default: r = 0;
    endcase
    if (upd) begin
      n = (r & msb) != 0;
      z = (r == 0);
    end
    r8 = r[7:0];
    return {1'b1, wr, n, v, f[2], z, c, r8};
  endfunction

  function automatic string tag_of(int opc);
    case (opc)
      0: return "R1 R2";
      1: return "R3 R2";
      2: return "R4";
      3, 4, 5: return "R5";
      6: return "R6";
      8, 10: return "R7";
      7, 9: return "R8";
      default: return "R13 R10";
    endcase
  endfunction

  task automatic check(string tag, logic [14:0] got, logic [14:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic run_op(int opc, int a, int m, logic [4:0] f);
    valid = 1'b1; op = opc[3:0]; a8 = a[7:0]; m8 = m[7:0]; fl = f;
    @(negedge clk);
    check(tag_of(opc), {v8_o, wr8_o, fl8_o, res8_o}, ref_fn(8, opc, a, m, f));
    check(tag_of(opc), {v4_o, wr4_o, fl4_o, 4'h0, res4_o},
          ref_fn(4, opc, a & 15, m & 15, f));
  endtask

  initial begin
    logic [14:0] d0, d1;
    #5;
    // R12 reset state
    check("R12", {v8_o, wr8_o, fl8_o, res8_o}, '0);
    check("R12", {v4_o, wr4_o, fl4_o, 4'h0, res4_o}, '0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // exhaustive at W=4, all codes, both carries
    for (int opc = 0; opc < 16; opc++)
      for (int a = 0; a < 16; a++)
        for (int m = 0; m < 16; m++)
          for (int c = 0; c < 2; c++)
            run_op(opc, a, m, {a[1] ^ m[0], m[2], a[0], m[3] ^ a[2], c[0]});

    // strided sweep at W=8 including 0x00 and 0xFF
    for (int opc = 0; opc < 16; opc++)
      for (int a = 0; a < 256; a += 5)
        for (int m = 0; m < 256; m += 5)
          for (int c = 0; c < 2; c++)
            run_op(opc, a, m, {a[1] ^ m[0], m[6], a[0], m[3] ^ a[2], c[0]});

    // signed overflow corners, R2
    run_op(0, 8'h7f, 8'h00, 5'b00001);
    run_op(0, 8'h80, 8'hff, 5'b00000);
    run_op(1, 8'h80, 8'h00, 5'b00000);
    run_op(1, 8'h7f, 8'hff, 5'b00001);

    // R9: decimal flag has no effect on add result
    run_op(0, 8'h19, 8'h28, 5'b00000);
    d0 = {v8_o, wr8_o, fl8_o, res8_o};
    run_op(0, 8'h19, 8'h28, 5'b00100);
    d1 = {v8_o, wr8_o, fl8_o, res8_o};
    check("R9", d1 & ~15'h0400, d0);
    check("R9", {14'h0, d1[10]}, 15'h1);

    // R11 and R10: idle cycle holds outputs, drops valid and write
    run_op(3, 8'hf0, 8'h3c, 5'b11111);
    d0 = {v8_o, wr8_o, fl8_o, res8_o};
    valid = 1'b0; op = 4'd0; a8 = 8'h01; m8 = 8'h01; fl = 5'b0;
    @(negedge clk);
    check("R11", {v8_o, wr8_o, fl8_o, res8_o}, {2'b00, d0[12:0]});
    check("R10", {14'h0, wr8_o}, 15'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R11 watchdog: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule